// File: doc/BRIEF.md
# Self-Test Launch Control Register

This block is a single 32-bit control word that software uses to start a hardware self-test on one or both of two processor cores. Two 4-bit fields are writable: a core-select field that chooses which cores take part, and an enable-key field that starts the run when it is loaded with the magic value Ah. The rest of the word is fixed at zero. Only writes flagged as privileged reach the fields.

The core-select field can be loaded once, from its empty value 0000. After that it is frozen for the rest of the run, so the choice of cores cannot change while a test is in flight. When the key field newly takes the value Ah and a core choice is present, the block issues a one-cycle start pulse on the request line of each selected core. When the external self-test engine reports completion, the whole word returns to its reset contents. This unlocks the selection and disarms the key. Software is expected to load the core selection before, or together with, the key.

Top module: `selftest_launch_reg`

## Requirements
- R1: A read strobe at address 04h returns, one cycle later with `bus_rvalid` high, the word whose bits 11:8 hold the core-select field and bits 3:0 hold the key field. All other bits read 0, whatever was written to them.
- R2: A write with `bus_priv` low changes neither field and produces no start pulse.
- R3: During and after reset the core-select field is 0000, the key field is 0101 and `core_req` is 00.
- R4: A privileged write loads the core-select field only while that field is 0000. Once it is nonzero, the field keeps its value until completion, even when the same write changes the key.
- R5: A start pulse happens only when the key field changes from a value other than Ah to Ah. Rewriting Ah over Ah, or loading any other key value, starts nothing.
- R6: The pulse pattern on `core_req` (bit 0 = core 1, bit 1 = core 2) is 01 for selection 5h, 10 for selection Ah and 11 for any other nonzero selection.
- R7: A `test_done` pulse returns the core-select field to 0000 and the key field to 0101 on the next clock, after which a new selection can be written.
- R8: The start pulse lasts exactly one cycle and appears in the cycle after the arming write. A single write that sets both fields uses the newly written selection. A key of Ah with a selection of 0000 gives no pulse.
- R9: When `test_done` and a write occur in the same cycle, the completion wins: the register ends at its defaults and no pulse is issued.
- R10: A write or read whose address is not 04h leaves the register unchanged and does not raise `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data, all lanes written together |
| bus_priv | input | 1 | High for a privileged access |
| test_done | input | 1 | One-cycle completion pulse from the self-test engine |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| core_req | output | 2 | One-cycle start request per core (bit 0 core 1, bit 1 core 2) |

## Verification
A corrupted core-select or key field shows on the next register read of offset 04h. It also shows in the very next cycle as a missing, extra or wrongly shaped pulse on `core_req`. A broken lock lets a second write overwrite the selection, and the mismatch appears in the following readback. A completion that is mishandled leaves stale fields that the read right after the completion pulse exposes. Sweeping every pair of field values from reset in one write covers the decode and the pulse-arming condition in full.

// File: rtl/stl_pkg.sv
package stl_pkg;
  localparam int FIELD_W = 4;
  localparam int NCORE   = 2;

  typedef logic [FIELD_W-1:0] nib_t;
  typedef logic [NCORE-1:0]   req_t;

  localparam nib_t SEL_EMPTY = 4'h0;
  localparam nib_t KEY_RST   = 4'h5;
  localparam nib_t KEY_GO    = 4'hA;
  localparam nib_t SEL_CORE1 = 4'h5;
  localparam nib_t SEL_CORE2 = 4'hA;

  // Map a core-select code to per-core request bits.
  function automatic req_t decode_sel(nib_t s);
    req_t r;
    if (s == SEL_CORE1)      r = 2'b01;
    else if (s == SEL_CORE2) r = 2'b10;
    else                     r = 2'b11;
    return r;
  endfunction
endpackage

// File: rtl/stl_bus_port.sv
module stl_bus_port #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int REG_ADDR = 4,
  parameter int SEL_LSB  = 8,
  parameter int KEY_LSB  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_priv,
  input  stl_pkg::nib_t     sel_q,
  input  stl_pkg::nib_t     key_q,
  output logic              wr_ok,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

  logic              hit;
  logic              rd_hit;
  logic [DATA_W-1:0] rword;

  assign hit    = (bus_addr == HIT_ADDR);
  assign wr_ok  = bus_wr & hit & bus_priv;
  assign rd_hit = bus_rd & hit;

  // Assemble the visible word; unused bits stay zero.
  always_comb begin
    rword = '0;
    rword[SEL_LSB +: stl_pkg::FIELD_W] = sel_q;
    rword[KEY_LSB +: stl_pkg::FIELD_W] = key_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_hit;
      bus_rdata  <= rd_hit ? rword : '0;
    end
  end
endmodule

// File: rtl/stl_field_store.sv
module stl_field_store #(
  parameter int DATA_W  = 32,
  parameter int SEL_LSB = 8,
  parameter int KEY_LSB = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              test_done,
  input  logic              wr_ok,
  input  logic [DATA_W-1:0] wdata,
  output stl_pkg::nib_t     sel_q,
  output stl_pkg::nib_t     key_q,
  output stl_pkg::nib_t     sel_d,
  output stl_pkg::nib_t     key_d
);
  import stl_pkg::*;

  // Next-state logic: completion first, then privileged write.
  always_comb begin
    sel_d = sel_q;
    key_d = key_q;
    if (test_done) begin
      sel_d = SEL_EMPTY;
      key_d = KEY_RST;
    end else if (wr_ok) begin
      if (sel_q == SEL_EMPTY) sel_d = wdata[SEL_LSB +: FIELD_W];
      key_d = wdata[KEY_LSB +: FIELD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= SEL_EMPTY;
      key_q <= KEY_RST;
    end else begin
      sel_q <= sel_d;
      key_q <= key_d;
    end
  end
endmodule

// File: rtl/stl_launch.sv
module stl_launch (
  input  logic          clk,
  input  logic          rst,
  input  stl_pkg::nib_t key_q,
  input  stl_pkg::nib_t key_d,
  input  stl_pkg::nib_t sel_d,
  output stl_pkg::req_t core_req
);
  import stl_pkg::*;

  logic arm;
  req_t pattern;

  assign arm     = (key_d == KEY_GO) && (key_q != KEY_GO) && (sel_d != SEL_EMPTY);
  assign pattern = decode_sel(sel_d);

  generate
    for (genvar c = 0; c < NCORE; c++) begin : g_core
      always_ff @(posedge clk) begin
        if (rst) core_req[c] <= 1'b0;
        else     core_req[c] <= arm & pattern[c];
      end
    end
  endgenerate
endmodule

// File: rtl/selftest_launch_reg.sv
module selftest_launch_reg #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int REG_ADDR = 4,
  parameter int SEL_LSB  = 8,
  parameter int KEY_LSB  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_priv,
  input  logic              test_done,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic [1:0]        core_req
);
  stl_pkg::nib_t sel_q, key_q, sel_d, key_d;
  logic          wr_ok;

  stl_bus_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR),
    .SEL_LSB(SEL_LSB), .KEY_LSB(KEY_LSB)
  ) u_bus (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_priv(bus_priv),
    .sel_q(sel_q), .key_q(key_q), .wr_ok(wr_ok),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  stl_field_store #(
    .DATA_W(DATA_W), .SEL_LSB(SEL_LSB), .KEY_LSB(KEY_LSB)
  ) u_store (
    .clk(clk), .rst(rst), .test_done(test_done), .wr_ok(wr_ok),
    .wdata(bus_wdata), .sel_q(sel_q), .key_q(key_q),
    .sel_d(sel_d), .key_d(key_d)
  );

  stl_launch u_launch (
    .clk(clk), .rst(rst), .key_q(key_q), .key_d(key_d),
    .sel_d(sel_d), .core_req(core_req)
  );
endmodule

// File: rtl/stl_checker.sv
module stl_checker #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int REG_ADDR = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_priv,
  input logic              test_done,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic [1:0]        core_req,
  input logic [3:0]        sel_q,
  input logic [3:0]        key_q
);
  logic at_reg;
  assign at_reg = (bus_addr == ADDR_W'(REG_ADDR));

  // R2: unprivileged write leaves both fields alone
  a_r2_user_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_priv && !test_done) |=> ($stable(sel_q) && $stable(key_q)));

  // R4: a nonzero selection holds until completion
  a_r4_sel_locked: assert property (@(posedge clk) disable iff (rst)
    (sel_q != 4'h0 && !test_done) |=> $stable(sel_q));

  // R7: completion restores defaults
  a_r7_done_clears: assert property (@(posedge clk) disable iff (rst)
    test_done |=> (sel_q == 4'h0 && key_q == 4'h5));

  // R5: any request comes with an armed key and a selection
  a_r5_req_needs_key: assert property (@(posedge clk) disable iff (rst)
    (core_req != 2'b00) |-> (key_q == 4'hA && sel_q != 4'h0));

  // R8: the pulse is a single cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (core_req != 2'b00) |=> (core_req == 2'b00));

  // R9: completion in a write cycle yields no pulse
  a_r9_done_wins: assert property (@(posedge clk) disable iff (rst)
    test_done |=> (core_req == 2'b00));

  // R1: read valid follows a matching read strobe
  a_r1_rvalid: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && at_reg) |=> bus_rvalid);

  // R1: reserved bits read as zero
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> (bus_rdata[31:12] == '0 && bus_rdata[7:4] == '0));

  // R10: no valid for an access to another address
  a_r10_no_stray_valid: assert property (@(posedge clk) disable iff (rst)
    (!(bus_rd && at_reg)) |=> !bus_rvalid);
endmodule

bind selftest_launch_reg stl_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_priv(bus_priv), .test_done(test_done),
  .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .core_req(core_req),
  .sel_q(sel_q), .key_q(key_q)
);

// File: tb/selftest_launch_reg_test.sv
module selftest_launch_reg_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_priv = 1'b0, test_done = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [1:0]  core_req;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  selftest_launch_reg uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_priv(bus_priv),
    .test_done(test_done), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .core_req(core_req)
  );

  function automatic logic [1:0] exp_req(logic [3:0] s);
    if (s == 4'h5) return 2'b01;
    if (s == 4'hA) return 2'b10;
    return 2'b11;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  // Drive one write cycle; returns at the next falling edge.
  task automatic do_write(logic [7:0] a, logic [31:0] d, logic p, logic dn);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_priv = p; test_done = dn;
    @(negedge clk);
    bus_wr = 1'b0; bus_priv = 1'b0; test_done = 1'b0;
  endtask

  task automatic do_done();
    @(negedge clk); test_done = 1'b1;
    @(negedge clk); test_done = 1'b0;
  endtask

  task automatic do_read(string req, logic [7:0] a, logic expv, logic [31:0] expd);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, {31'b0, bus_rvalid}, {31'b0, expv});
    if (expv) chk(req, bus_rdata, expd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R3: reset state
    @(negedge clk); @(negedge clk);
    chk("R3 req in reset", {30'b0, core_req}, 32'h0);
    rst = 1'b0;
    do_read("R3 defaults", 8'h04, 1'b1, 32'h0000_0005);

    // R6/R8/R5: every field pair in one privileged write from reset
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 16; k++) begin
        logic [1:0] e;
        do_reset();
        do_write(8'h04, {20'hFFFFF, s[3:0], 4'hF, k[3:0]}, 1'b1, 1'b0);
        e = (k == 10 && s != 0) ? exp_req(s[3:0]) : 2'b00;
        chk("R6 R8 sweep pulse", {30'b0, core_req}, {30'b0, e});
        do_read("R1 sweep readback", 8'h04, 1'b1, {20'b0, s[3:0], 4'b0, k[3:0]});
      end
    end

    // R2: user-mode writes ignored
    for (int s = 1; s < 16; s += 3) begin
      do_reset();
      do_write(8'h04, {20'b0, s[3:0], 4'b0, 4'hA}, 1'b0, 1'b0);
      chk("R2 user write no pulse", {30'b0, core_req}, 32'h0);
      do_read("R2 user write ignored", 8'h04, 1'b1, 32'h0000_0005);
    end

    // R4: selection locked once nonzero; R8 pulse lasts one cycle
    do_reset();
    do_write(8'h04, 32'h0000_0505, 1'b1, 1'b0);
    chk("R4 no pulse yet", {30'b0, core_req}, 32'h0);
    do_write(8'h04, 32'h0000_0A0A, 1'b1, 1'b0);
    chk("R4 locked sel drives core1", {30'b0, core_req}, 32'h1);
    @(negedge clk);
    chk("R8 pulse one cycle", {30'b0, core_req}, 32'h0);
    do_read("R4 sel kept", 8'h04, 1'b1, 32'h0000_050A);

    // R5: rewriting Ah over Ah starts nothing
    do_write(8'h04, 32'h0000_000A, 1'b1, 1'b0);
    chk("R5 no retrigger", {30'b0, core_req}, 32'h0);

    // R7: completion restores defaults, selection writable again
    do_done();
    do_read("R7 defaults after done", 8'h04, 1'b1, 32'h0000_0005);
    do_write(8'h04, 32'h0000_0A0A, 1'b1, 1'b0);
    chk("R7 new run core2", {30'b0, core_req}, 32'h2);

    // R8: key Ah with empty selection, then selection alone: no pulse
    do_reset();
    do_write(8'h04, 32'h0000_000A, 1'b1, 1'b0);
    chk("R8 empty sel no pulse", {30'b0, core_req}, 32'h0);
    do_write(8'h04, 32'h0000_030A, 1'b1, 1'b0);
    chk("R5 key unchanged no pulse", {30'b0, core_req}, 32'h0);
    do_read("R8 readback", 8'h04, 1'b1, 32'h0000_030A);

    // R9: completion wins over a same-cycle write
    do_reset();
    do_write(8'h04, 32'h0000_0C05, 1'b1, 1'b0);
    do_write(8'h04, 32'h0000_000A, 1'b1, 1'b1);
    chk("R9 no pulse with done", {30'b0, core_req}, 32'h0);
    do_read("R9 defaults", 8'h04, 1'b1, 32'h0000_0005);

    // R10: other addresses
    do_reset();
    do_write(8'h08, 32'h0000_050A, 1'b1, 1'b0);
    chk("R10 no pulse", {30'b0, core_req}, 32'h0);
    do_read("R10 stray read", 8'h08, 1'b0, 32'h0);
    do_read("R10 unchanged", 8'h04, 1'b1, 32'h0000_0005);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule